// File: doc/BRIEF.md
# Active-Low Network Interrupt Aggregator

The block gathers interrupt requests from network ports, grouped by slot, into one 16-bit status word per slot. A pending request shows as a zero bit, and an idle word reads as all ones. Two strobe inputs drive the words. A raise strobe makes a request pending. A drop strobe withdraws it. Each strobe carries a slot number and a port number, and the port number picks the bit inside that slot's word.

The block drives a single level-sensitive interrupt line to the processor. The line is registered. It is high while any bit in any status word is zero, and it falls only once every word is back to all ones.

A small register bus reads the status words. The same bus reads and writes a 16-bit interrupt mask. The mask is only storage for software and never gates the line. Reads are combinational from the address. Writes take effect on the clock edge while the write enable is high. The strobes and the bus are plain control pins with no handshake: every strobe or write presented on a clock edge is taken, so no back-pressure exists.

Top module: `net_irq_agg`

## Requirements
- R1: After reset both status words read 0xFFFF, the mask reads 0x0000 and the interrupt line is low.
- R2: A raise strobe for slot s (0 or 1) and port p (0 to 15) clears bit p of status word s on the next clock edge. Bit p is the bit with weight 2^p.
- R3: A drop strobe for slot s and port p sets bit p of status word s on the next clock edge.
- R4: When a raise and a drop address the same slot and port in one cycle, the raise wins and the bit ends cleared.
- R5: The interrupt line is a register. After each clock edge it is high if and only if, before that edge, some bit of status word 0 or status word 1 was zero. A change to the words therefore shows on the line one cycle later.
- R6: The bus read data returns:
  - status word 0 at address 0x26;
  - status word 1 at address 0x28;
  - the mask at address 0x30;
  - zero at every other address.
- R7: Bus writes to 0x26 or 0x28 leave both status words unchanged.
- R8: A bus write to 0x30 stores the write data as the mask, and it reads back from the next cycle on. The mask value never changes the interrupt line.
- R9: A strobe whose slot number is above 1, or whose port number is above 15, changes no status bit.
- R10: A raise and a drop for different bits in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| raise_vld | input | 1 | Raise strobe: the request becomes pending |
| raise_slot | input | 2 | Slot number of the raise strobe |
| raise_port | input | 5 | Port number of the raise strobe |
| drop_vld | input | 1 | Drop strobe: the request is withdrawn |
| drop_slot | input | 2 | Slot number of the drop strobe |
| drop_port | input | 5 | Port number of the drop strobe |
| bus_wr_en | input | 1 | Register write enable |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data, combinational from bus_addr |
| irq | output | 1 | Registered interrupt line, active high |

## Verification
The bench builds the block with its default parameters:
- two slots of 16 bits each;
- a 2-bit slot field and a 5-bit port field.

Because the fields are wider than the populated range, slot numbers 2 and 3 and port numbers 16 to 31 can reach the block. That lets the bench show that such strobes are discarded (R9).

With only 32 status bits, the random phase often withdraws every pending request. The line's falling edge (R5) is therefore exercised, alongside raise/drop collisions on one bit and on different bits (R4, R10).

// File: rtl/nia_pkg.sv
package nia_pkg;

  // What a bus address selects in the register file
  typedef enum logic [1:0] {
    NIA_SEL_NONE = 2'd0,
    NIA_SEL_STAT = 2'd1,
    NIA_SEL_MASK = 2'd2
  } nia_sel_e;

endpackage

// File: rtl/nia_strobe_decode.sv
// Turns one slot/port strobe into a flat one-hot vector, one word per slot.
// Out-of-range slot or port numbers match no bit and are thereby dropped.
module nia_strobe_decode #(
  parameter int unsigned NUM_SLOTS    = 2,
  parameter int unsigned WORD_W       = 16,
  parameter int unsigned SLOT_FIELD_W = 2,
  parameter int unsigned PORT_FIELD_W = 5,
  localparam int unsigned FLAT_W      = NUM_SLOTS * WORD_W
) (
  input  logic                    vld,
  input  logic [SLOT_FIELD_W-1:0] slot,
  input  logic [PORT_FIELD_W-1:0] port,
  output logic [FLAT_W-1:0]       hot
);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic slot_hit;
    assign slot_hit = vld && (slot == SLOT_FIELD_W'(s));
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      assign hot[s*WORD_W + b] = slot_hit && (port == PORT_FIELD_W'(b));
    end
  end

endmodule

// File: rtl/nia_status_word.sv
// One active-low pending word. Withdrawals set bits, raises clear them;
// the raise is applied last so it wins a collision on the same bit.
module nia_status_word #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] raise_hot,
  input  logic [WORD_W-1:0] drop_hot,
  output logic [WORD_W-1:0] word_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '1;
    else        word_q <= (word_q | drop_hot) & ~raise_hot;
  end

endmodule

// File: rtl/nia_regbus.sv
// Register bus: read mux over the status words and mask, mask storage.
module nia_regbus
  import nia_pkg::*;
#(
  parameter int unsigned NUM_SLOTS   = 2,
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned STAT_BASE   = 'h26,
  parameter int unsigned STAT_STRIDE = 2,
  parameter int unsigned MASK_ADDR   = 'h30,
  localparam int unsigned FLAT_W     = NUM_SLOTS * WORD_W,
  localparam int unsigned SEL_W      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [FLAT_W-1:0] stat_flat,
  output logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] mask_q
);

  nia_sel_e         sel_kind;
  logic [SEL_W-1:0] sel_slot;

  always_comb begin
    sel_kind = NIA_SEL_NONE;
    sel_slot = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (addr == ADDR_W'(STAT_BASE + s * STAT_STRIDE)) begin
        sel_kind = NIA_SEL_STAT;
        sel_slot = SEL_W'(s);
      end
    end
    if (addr == ADDR_W'(MASK_ADDR)) sel_kind = NIA_SEL_MASK;
  end

  always_comb begin
    unique case (sel_kind)
      NIA_SEL_STAT: rdata = stat_flat[sel_slot*WORD_W +: WORD_W];
      NIA_SEL_MASK: rdata = mask_q;
      default:      rdata = '0;
    endcase
  end

  // Status words are read-only: only the mask takes bus writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               mask_q <= '0;
    else if (wr_en && sel_kind == NIA_SEL_MASK) mask_q <= wdata;
  end

endmodule

// File: rtl/net_irq_agg.sv
module net_irq_agg #(
  parameter int unsigned NUM_SLOTS    = 2,
  parameter int unsigned WORD_W       = 16,
  parameter int unsigned SLOT_FIELD_W = 2,
  parameter int unsigned PORT_FIELD_W = 5,
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned STAT_BASE    = 'h26,
  parameter int unsigned STAT_STRIDE  = 2,
  parameter int unsigned MASK_ADDR    = 'h30
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    raise_vld,
  input  logic [SLOT_FIELD_W-1:0] raise_slot,
  input  logic [PORT_FIELD_W-1:0] raise_port,
  input  logic                    drop_vld,
  input  logic [SLOT_FIELD_W-1:0] drop_slot,
  input  logic [PORT_FIELD_W-1:0] drop_port,
  input  logic                    bus_wr_en,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [WORD_W-1:0]       bus_wdata,
  output logic [WORD_W-1:0]       bus_rdata,
  output logic                    irq
);

  localparam int unsigned FLAT_W = NUM_SLOTS * WORD_W;

  logic [FLAT_W-1:0] raise_hot;
  logic [FLAT_W-1:0] drop_hot;
  logic [FLAT_W-1:0] stat_flat;
  logic [WORD_W-1:0] mask_val;
  logic              irq_q;

  nia_strobe_decode #(
    .NUM_SLOTS(NUM_SLOTS), .WORD_W(WORD_W),
    .SLOT_FIELD_W(SLOT_FIELD_W), .PORT_FIELD_W(PORT_FIELD_W)
  ) u_raise_dec (
    .vld(raise_vld), .slot(raise_slot), .port(raise_port), .hot(raise_hot)
  );

  nia_strobe_decode #(
    .NUM_SLOTS(NUM_SLOTS), .WORD_W(WORD_W),
    .SLOT_FIELD_W(SLOT_FIELD_W), .PORT_FIELD_W(PORT_FIELD_W)
  ) u_drop_dec (
    .vld(drop_vld), .slot(drop_slot), .port(drop_port), .hot(drop_hot)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_word
    nia_status_word #(.WORD_W(WORD_W)) u_word (
      .clk      (clk),
      .rst_n    (rst_n),
      .raise_hot(raise_hot[s*WORD_W +: WORD_W]),
      .drop_hot (drop_hot[s*WORD_W +: WORD_W]),
      .word_q   (stat_flat[s*WORD_W +: WORD_W])
    );
  end

  // Level output: any zero anywhere means something is pending
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= ~&stat_flat;
  end
  assign irq = irq_q;

  nia_regbus #(
    .NUM_SLOTS(NUM_SLOTS), .WORD_W(WORD_W), .ADDR_W(ADDR_W),
    .STAT_BASE(STAT_BASE), .STAT_STRIDE(STAT_STRIDE), .MASK_ADDR(MASK_ADDR)
  ) u_regbus (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr_en),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .stat_flat(stat_flat),
    .rdata    (bus_rdata),
    .mask_q   (mask_val)
  );

endmodule

// File: rtl/net_irq_agg_chk.sv
module net_irq_agg_chk #(
  parameter int unsigned NUM_SLOTS    = 2,
  parameter int unsigned WORD_W       = 16,
  parameter int unsigned SLOT_FIELD_W = 2,
  parameter int unsigned PORT_FIELD_W = 5,
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned STAT_BASE    = 'h26,
  parameter int unsigned STAT_STRIDE  = 2,
  parameter int unsigned MASK_ADDR    = 'h30,
  localparam int unsigned FLAT_W      = NUM_SLOTS * WORD_W
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    raise_vld,
  input logic [SLOT_FIELD_W-1:0] raise_slot,
  input logic [PORT_FIELD_W-1:0] raise_port,
  input logic                    drop_vld,
  input logic [SLOT_FIELD_W-1:0] drop_slot,
  input logic [PORT_FIELD_W-1:0] drop_port,
  input logic                    bus_wr_en,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [WORD_W-1:0]       bus_wdata,
  input logic [FLAT_W-1:0]       stat_flat,
  input logic [WORD_W-1:0]       mask_q,
  input logic                    irq
);

  function automatic int bit_idx(input logic [SLOT_FIELD_W-1:0] s,
                                 input logic [PORT_FIELD_W-1:0] p);
    return int'(s) * WORD_W + int'(p);
  endfunction

  function automatic logic is_stat_addr(input logic [ADDR_W-1:0] a);
    logic hit = 1'b0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (a == ADDR_W'(STAT_BASE + s * STAT_STRIDE)) hit = 1'b1;
    return hit;
  endfunction

  logic raise_ok, drop_ok, same_bit;
  assign raise_ok = raise_vld && (int'(raise_slot) < NUM_SLOTS) && (int'(raise_port) < WORD_W);
  assign drop_ok  = drop_vld  && (int'(drop_slot)  < NUM_SLOTS) && (int'(drop_port)  < WORD_W);
  assign same_bit = raise_ok && drop_ok && raise_slot == drop_slot && raise_port == drop_port;

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (stat_flat == '1 && !irq && mask_q == '0));

  assert_raise_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    raise_ok |=> !stat_flat[bit_idx($past(raise_slot), $past(raise_port))]);

  assert_drop_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_ok && !same_bit) |=> stat_flat[bit_idx($past(drop_slot), $past(drop_port))]);

  assert_collision_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    same_bit |=> !stat_flat[bit_idx($past(raise_slot), $past(raise_port))]);

  assert_line_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(stat_flat != '1)));

  assert_stat_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && is_stat_addr(bus_addr) && !raise_vld && !drop_vld) |=> $stable(stat_flat));

  assert_mask_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == ADDR_W'(MASK_ADDR)) |=> (mask_q == $past(bus_wdata)));

  assert_bad_strobe_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((raise_vld || drop_vld) && !raise_ok && !drop_ok) |=> $stable(stat_flat));

endmodule

bind net_irq_agg net_irq_agg_chk #(
  .NUM_SLOTS(NUM_SLOTS), .WORD_W(WORD_W), .SLOT_FIELD_W(SLOT_FIELD_W),
  .PORT_FIELD_W(PORT_FIELD_W), .ADDR_W(ADDR_W), .STAT_BASE(STAT_BASE),
  .STAT_STRIDE(STAT_STRIDE), .MASK_ADDR(MASK_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .raise_vld(raise_vld), .raise_slot(raise_slot), .raise_port(raise_port),
  .drop_vld(drop_vld), .drop_slot(drop_slot), .drop_port(drop_port),
  .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .stat_flat(stat_flat), .mask_q(mask_val), .irq(irq)
);

// File: tb/net_irq_agg_test.sv
module net_irq_agg_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        raise_vld = 1'b0;
  logic [1:0]  raise_slot = '0;
  logic [4:0]  raise_port = '0;
  logic        drop_vld = 1'b0;
  logic [1:0]  drop_slot = '0;
  logic [4:0]  drop_port = '0;
  logic        bus_wr_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int n_checks = 0;
  int n_errors = 0;

  logic [15:0] exp_w0 = 16'hFFFF;
  logic [15:0] exp_w1 = 16'hFFFF;
  logic [15:0] exp_mask = 16'h0000;
  logic        exp_irq = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  net_irq_agg uut (
    .clk(clk), .rst_n(rst_n),
    .raise_vld(raise_vld), .raise_slot(raise_slot), .raise_port(raise_port),
    .drop_vld(drop_vld), .drop_slot(drop_slot), .drop_port(drop_port),
    .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  // Next value of one pending word, from the requirements (R2, R3, R4, R9)
  function automatic logic [15:0] next_word(input logic [15:0] w, input int slot,
      input bit rv, input int rs, input int rp, input bit dv, input int ds, input int dp);
    logic [15:0] n = w;
    if (dv && ds == slot && dp < 16) n[dp] = 1'b1;
    if (rv && rs == slot && rp < 16) n[rp] = 1'b0;
    return n;
  endfunction

  task automatic read_all(input string tag);
    bus_addr = 8'h26; #1; check({tag, " word0"}, bus_rdata, exp_w0);
    bus_addr = 8'h28; #1; check({tag, " word1"}, bus_rdata, exp_w1);
    bus_addr = 8'h30; #1; check({tag, " mask"},  bus_rdata, exp_mask);
  endtask

  // One clock cycle of stimulus; optional register readback before the edge
  task automatic cyc(input bit rv, input int rs, input int rp,
                     input bit dv, input int ds, input int dp,
                     input bit wr, input logic [7:0] addr, input logic [15:0] wd,
                     input bit do_read, input string tag);
    @(negedge clk);
    raise_vld = rv; raise_slot = 2'(rs); raise_port = 5'(rp);
    drop_vld  = dv; drop_slot  = 2'(ds); drop_port  = 5'(dp);
    bus_wr_en = wr; bus_wdata = wd;
    if (do_read && !wr) read_all(tag);
    bus_addr = addr;
    @(posedge clk);
    exp_irq = (exp_w0 != 16'hFFFF) || (exp_w1 != 16'hFFFF);
    exp_w0 = next_word(exp_w0, 0, rv, rs, rp, dv, ds, dp);
    exp_w1 = next_word(exp_w1, 1, rv, rs, rp, dv, ds, dp);
    if (wr && addr == 8'h30) exp_mask = wd;
    #2;
    check("R5 irq line", {15'd0, irq}, {15'd0, exp_irq});
  endtask

  task automatic idle_read(input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 8'h00, 16'h0, 1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset values
    idle_read("R1 reset");
    check("R1 irq low", {15'd0, irq}, 16'd0);

    // R2/R5: raise slot0 port5; line still low on the edge that changes the word
    cyc(1, 0, 5, 0, 0, 0, 0, 8'h00, 16'h0, 0, "R2");
    check("R5 delayed line", {15'd0, irq}, 16'd0);
    idle_read("R2 raise");
    check("R2 word0 value", exp_w0, 16'hFFDF);
    check("R5 line high", {15'd0, irq}, 16'd1);

    // R10/R3: raise slot1 port15 while dropping slot0 port5
    cyc(1, 1, 15, 1, 0, 5, 0, 8'h00, 16'h0, 0, "R10");
    idle_read("R10 R3 different bits");

    // R4: same-bit collision on slot1 port0
    cyc(1, 1, 0, 1, 1, 0, 0, 8'h00, 16'h0, 0, "R4");
    idle_read("R4 collision");
    check("R4 word1 value", exp_w1, 16'h7FFE);

    // R7: writes to the status addresses
    cyc(0, 0, 0, 0, 0, 0, 1, 8'h26, 16'h0000, 0, "R7");
    cyc(0, 0, 0, 0, 0, 0, 1, 8'h28, 16'hFFFF, 0, "R7");
    idle_read("R7 status write ignored");

    // R8: mask all ones, then withdraw everything; line must still fall
    cyc(0, 0, 0, 0, 0, 0, 1, 8'h30, 16'hFFFF, 0, "R8");
    for (int p = 0; p < 16; p++) cyc(0, 0, 0, 1, 1, p, 0, 8'h00, 16'h0, 0, "R8");
    idle_read("R8 mask kept");
    idle_read("R8 line low");
    check("R8 irq low under mask", {15'd0, irq}, 16'd0);

    // R9: out-of-range slot and port
    cyc(1, 2, 3, 0, 0, 0, 0, 8'h00, 16'h0, 0, "R9");
    cyc(1, 0, 20, 0, 0, 0, 0, 8'h00, 16'h0, 0, "R9");
    cyc(1, 3, 31, 0, 0, 0, 0, 8'h00, 16'h0, 0, "R9");
    idle_read("R9 bad strobe ignored");
    check("R9 irq stays low", {15'd0, irq}, 16'd0);

    // R6: unmapped address reads zero
    @(negedge clk);
    bus_addr = 8'h2A; #1; check("R6 unmapped 0x2A", bus_rdata, 16'h0000);
    bus_addr = 8'h00; #1; check("R6 unmapped 0x00", bus_rdata, 16'h0000);

    // Random phase
    for (int i = 0; i < 600; i++) begin
      bit rv = 1'($urandom % 2);
      bit dv = ($urandom % 4) != 0;
      int rs = ($urandom % 8 == 0) ? 2 + int'($urandom % 2) : int'($urandom % 2);
      int rp = ($urandom % 8 == 0) ? 16 + int'($urandom % 16) : int'($urandom % 16);
      int ds = ($urandom % 8 == 0) ? 2 + int'($urandom % 2) : int'($urandom % 2);
      int dp = ($urandom % 8 == 0) ? 16 + int'($urandom % 16) : int'($urandom % 16);
      bit wr = ($urandom % 6) == 0;
      logic [7:0] addr;
      case ($urandom % 4)
        0: addr = 8'h26;
        1: addr = 8'h28;
        2: addr = 8'h30;
        default: addr = 8'h2C;
      endcase
      if ($urandom % 10 == 0) begin ds = rs; dp = rp; end
      if ($urandom % 7 == 0) rv = 1'b0;
      cyc(rv, rs, rp, dv, ds, dp, wr, addr, 16'($urandom),
          (i % 3) == 0, "R2/R3/R4/R6/R9/R10 random");
    end
    idle_read("R6 final readback");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule